// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates every timing signal a character-cell display controller needs. It runs on the pixel (dot) clock. A small dot counter groups dots into character cells of eight dots each. The character counter advances once per cell and steps a scanline counter at the end of each line. The scanline counter returns to zero at the end of each frame.

Twelve threshold inputs set the shape of the raster. Six are horizontal and given in characters; six are vertical and given in scanlines. Each axis has:

- an active-area end,
- a blanking window (start and end),
- a sync window (start and end),
- a period (total).

The block compares the thresholds against the running counts to produce the active-video enable, the blanking and sync pulses, and a border flag. The border flag marks the overscan band that lies between the active area and blanking.

A typical setting uses 100 characters per line (800 dots) and 525 lines. At a 25.2 MHz dot clock this gives a 31.5 kHz line rate and a 60 Hz frame rate. The thresholds are expected to be held constant while the block runs. They are changed only while reset is asserted.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `char_cnt` and `line_cnt` are zero.
- R2: `char_cnt` advances by one exactly once every 8 dot clocks. The first advance occurs on the 8th rising edge after reset release.
- R3: `char_cnt` counts from 0 to `h_total`-1. On the character step after `h_total`-1 it returns to 0 and `line_cnt` increments. `line_cnt` changes at no other time.
- R4: `line_cnt` counts from 0 to `v_total`-1. The line step after `v_total`-1 returns both counters to 0.
- R5: `disp_en` is 1 exactly when `char_cnt` < `h_disp_end` and `line_cnt` < `v_disp_end`.
- R6: `blank` is 1 when either of two conditions holds: `h_blank_start` <= `char_cnt` < `h_blank_end`, or `v_blank_start` <= `line_cnt` < `v_blank_end`.
- R7: `hsync` is 1 exactly when `h_sync_start` <= `char_cnt` < `h_sync_end`. The pulse is active high.
- R8: `vsync` is 1 exactly when `v_sync_start` <= `line_cnt` < `v_sync_end`. The pulse is active high.
- R9: `border` is 1 exactly when both `disp_en` and `blank` are 0.
- R10: One line lasts 8*`h_total` dot clocks and one frame lasts 8*`h_total`*`v_total` dot clocks. With 100 characters and 525 lines, `line_cnt` reads 1 exactly 800 cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_disp_end | input | 8 | Horizontal active-area end, in characters |
| h_blank_start | input | 8 | Horizontal blanking start, in characters |
| h_sync_start | input | 8 | Horizontal sync start, in characters |
| h_sync_end | input | 8 | Horizontal sync end (exclusive), in characters |
| h_blank_end | input | 8 | Horizontal blanking end (exclusive), in characters |
| h_total | input | 8 | Characters per line |
| v_disp_end | input | 10 | Vertical active-area end, in lines |
| v_blank_start | input | 10 | Vertical blanking start, in lines |
| v_sync_start | input | 10 | Vertical sync start, in lines |
| v_sync_end | input | 10 | Vertical sync end (exclusive), in lines |
| v_blank_end | input | 10 | Vertical blanking end (exclusive), in lines |
| v_total | input | 10 | Lines per frame |
| disp_en | output | 1 | Active video area |
| border | output | 1 | Overscan band: neither active nor blanked |
| blank | output | 1 | Blanking on either axis |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |
| char_cnt | output | 8 | Current character position in the line |
| line_cnt | output | 10 | Current scanline in the frame |

## Verification
The embedded assertions check the counter mechanics on every cycle:

- the character count moves only at the eighth dot of a cell;
- it stays below the programmed total and wraps to zero at it;
- the line count moves only on a character wrap and wraps to zero at the frame end.

The bench's scenarios cover what the assertions cannot. The bench tracks the dot position itself and compares every decoded output against windows computed from the thresholds. It does this for:

- the standard 100 by 525 setting;
- a compact mode that crosses a full frame boundary;
- a mode whose sync window starts at character zero and whose active area is empty.

The bench alone shows the exact line period and the placement of the border band.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CELL_DOTS = 8,
  parameter int HW = 8,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_disp_end,
  input  logic [HW-1:0] h_blank_start,
  input  logic [HW-1:0] h_sync_start,
  input  logic [HW-1:0] h_sync_end,
  input  logic [HW-1:0] h_blank_end,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_disp_end,
  input  logic [VW-1:0] v_blank_start,
  input  logic [VW-1:0] v_sync_start,
  input  logic [VW-1:0] v_sync_end,
  input  logic [VW-1:0] v_blank_end,
  input  logic [VW-1:0] v_total,
  output logic          disp_en,
  output logic          border,
  output logic          blank,
  output logic          hsync,
  output logic          vsync,
  output logic [HW-1:0] char_cnt,
  output logic [VW-1:0] line_cnt
);
  localparam int DW = (CELL_DOTS > 1) ? $clog2(CELL_DOTS) : 1;
  localparam logic [DW-1:0] DOT_LAST = DW'(CELL_DOTS - 1);

  logic [DW-1:0] dot_cnt;
  logic dot_last, char_last, line_last;

  assign dot_last  = (dot_cnt == DOT_LAST);
  assign char_last = (char_cnt == h_total - HW'(1));
  assign line_last = (line_cnt == v_total - VW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_cnt  <= '0;
      char_cnt <= '0;
      line_cnt <= '0;
    end else if (!dot_last) begin
      dot_cnt <= dot_cnt + DW'(1);
    end else begin
      dot_cnt <= '0;
      if (!char_last) begin
        char_cnt <= char_cnt + HW'(1);
      end else begin
        char_cnt <= '0;
        line_cnt <= line_last ? '0 : line_cnt + VW'(1);
      end
    end
  end

  logic h_act, v_act, h_blk, v_blk;

  assign h_act = char_cnt < h_disp_end;
  assign v_act = line_cnt < v_disp_end;
  assign h_blk = (char_cnt >= h_blank_start) && (char_cnt < h_blank_end);
  assign v_blk = (line_cnt >= v_blank_start) && (line_cnt < v_blank_end);

  assign hsync   = (char_cnt >= h_sync_start) && (char_cnt < h_sync_end);
  assign vsync   = (line_cnt >= v_sync_start) && (line_cnt < v_sync_end);
  assign disp_en = h_act && v_act;
  assign blank   = h_blk || v_blk;
  assign border  = !disp_en && !blank;

  // R2
  char_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_cnt != $past(char_cnt)) |-> ($past(dot_cnt) == DOT_LAST));

  // R3
  char_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_cnt < h_total);

  // R3
  char_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_last && char_last) |=> (char_cnt == '0));

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt != $past(line_cnt)) |-> (char_cnt == '0));

  // R4
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_last && char_last && line_last) |=> (line_cnt == '0 && char_cnt == '0));
endmodule

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] hde, hbs, hss, hse, hbe, htot;
  logic [9:0] vde, vbs, vss, vse, vbe, vtot;
  logic disp_en, border, blank, hsync, vsync;
  logic [7:0] char_cnt;
  logic [9:0] line_cnt;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  raster_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_disp_end(hde), .h_blank_start(hbs), .h_sync_start(hss),
    .h_sync_end(hse), .h_blank_end(hbe), .h_total(htot),
    .v_disp_end(vde), .v_blank_start(vbs), .v_sync_start(vss),
    .v_sync_end(vse), .v_blank_end(vbe), .v_total(vtot),
    .disp_en(disp_en), .border(border), .blank(blank),
    .hsync(hsync), .vsync(vsync), .char_cnt(char_cnt), .line_cnt(line_cnt)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_mode(int a0, int a1, int a2, int a3, int a4, int a5,
                          int b0, int b1, int b2, int b3, int b4, int b5);
    rst_n = 1'b0;
    hde = 8'(a0); hbs = 8'(a1); hss = 8'(a2); hse = 8'(a3); hbe = 8'(a4); htot = 8'(a5);
    vde = 10'(b0); vbs = 10'(b1); vss = 10'(b2); vse = 10'(b3); vbe = 10'(b4); vtot = 10'(b5);
    repeat (2) @(negedge clk);
    chk("R1 char in reset", int'(char_cnt), 0);
    chk("R1 line in reset", int'(line_cnt), 0);
    rst_n = 1'b1;
  endtask

  task automatic run_cycles(int n);
    int h = int'(htot);
    int v = int'(vtot);
    for (int i = 0; i < n; i++) begin
      int p = i % (8 * h * v);
      int c = (p / 8) % h;
      int l = p / (8 * h);
      bit ea = (c < int'(hde)) && (l < int'(vde));
      bit eb = ((c >= int'(hbs)) && (c < int'(hbe))) || ((l >= int'(vbs)) && (l < int'(vbe)));
      chk("R2/R3 char_cnt", int'(char_cnt), c);
      chk("R3/R4 line_cnt", int'(line_cnt), l);
      chk("R5 disp_en", int'(disp_en), int'(ea));
      chk("R6 blank", int'(blank), int'(eb));
      chk("R7 hsync", int'(hsync), int'((c >= int'(hss)) && (c < int'(hse))));
      chk("R8 vsync", int'(vsync), int'((l >= int'(vss)) && (l < int'(vse))));
      chk("R9 border", int'(border), int'(!ea && !eb));
      @(negedge clk);
    end
  endtask

  task automatic t_reference_line();
    set_mode(80, 81, 84, 96, 99, 100, 480, 487, 489, 498, 516, 525);
    chk("R1 char after release", int'(char_cnt), 0);
    run_cycles(800);
    chk("R10 line after 800 dots", int'(line_cnt), 1);
    chk("R10 char after 800 dots", int'(char_cnt), 0);
    repeat (7) @(negedge clk);
    chk("R2 char before 8th dot", int'(char_cnt), 0);
    @(negedge clk);
    chk("R2 char at 8th dot", int'(char_cnt), 1);
  endtask

  task automatic t_small_frames();
    set_mode(4, 5, 6, 8, 9, 10, 3, 4, 5, 6, 7, 8);
    run_cycles(1500);
  endtask

  task automatic t_frame_wrap_edge();
    set_mode(2, 3, 0, 2, 4, 5, 0, 1, 0, 1, 2, 3);
    repeat (119) @(negedge clk);
    chk("R4 line at last dot of frame", int'(line_cnt), 2);
    chk("R4 char at last dot of frame", int'(char_cnt), 4);
    @(negedge clk);
    chk("R4 line after frame wrap", int'(line_cnt), 0);
    chk("R4 char after frame wrap", int'(char_cnt), 0);
    chk("R7 hsync at char 0", int'(hsync), 1);
    chk("R8 vsync at line 0", int'(vsync), 1);
    set_mode(2, 3, 0, 2, 4, 5, 0, 1, 0, 1, 2, 3);
    run_cycles(300);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reference_line();
    t_small_frames();
    t_frame_wrap_edge();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule